// File: doc/BRIEF.md
# Run-Length Bit Expander

The expander turns a byte stream that holds a run-length-compressed configuration image into a serial stream of single bits. Bytes arrive under a valid/ready handshake with an end-of-stream marker. Bits leave under a second valid/ready handshake, and a last marker flags the final bit.

Each stream starts with a search for the payload. Leading bytes are thrown away until a sync pair turns up. The expander then sends a fixed 16-bit header. After that it turns each code byte into a run of ones, a run of zeros, or a run of one value closed by a single bit of the other value. The threshold that separates the ones classes from the zeros classes is the parameter `MAX_ONES`, 226 by default.

While a run is being sent, the input side is held off. Each code is therefore finished before the next byte is taken. When a stream ends, the block returns on its own to searching for the next sync pair.

Top module: `rlx_stream_expander`

## Requirements
- R1: While reset is held and in the cycle after it, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: Bytes are discarded, with no output, until a byte equal to 0xFF is followed directly by a byte whose bits [7:4] equal 4'h3. Both bytes of this pair are consumed and are not decoded as codes.
- R3: Right after the sync pair, the first 16 output bits are 1,1,1,1,1,1,1,1,0,0,1,0,0,0,0,0, in that order. This is the word 16'hFF20 sent from its most significant bit.
- R4: A code byte b with 1 <= b <= MAX_ONES gives b one-bits followed by one zero-bit.
- R5: The code byte MAX_ONES+1 gives MAX_ONES one-bits and no closing zero.
- R6: A code byte b with MAX_ONES+2 <= b <= 254 gives b-(MAX_ONES+2) zero-bits followed by one one-bit, so b = MAX_ONES+2 gives a single one. The code byte 255 gives a single one-bit.
- R7: The code byte 0 gives no output bits and is consumed.
- R8: `in_ready` is 0 in every cycle where `out_valid` is 1. A byte is therefore taken only after all bits of the previous code have been sent.
- R9: When `out_valid` is 1 and `out_ready` is 0, in the next cycle `out_valid` is still 1 and `out_bit` and `out_last` are unchanged. No bit is dropped or repeated.
- R10: `out_last` is 1 only on the final bit produced by the byte that carried `in_last`, whether that byte is the sync byte or a code. After that bit the block searches for a new sync pair. A zero code carrying `in_last` produces no `out_last` and also returns the block to the search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is valid |
| in_last | input | 1 | This byte ends the stream |
| in_ready | output | 1 | The block takes a byte in this cycle |
| out_bit | output | 1 | Output bit |
| out_valid | output | 1 | Output bit is valid |
| out_ready | input | 1 | Downstream takes the bit |
| out_last | output | 1 | Final bit of the stream |

## Verification
The final bit of a stream can be stalled: `out_last` is high in the same cycle that downstream holds `out_ready` low. The bench provokes this by running its streams under pseudo-random backpressure. It then checks that the last marker and the bit stay fixed for the whole stall and appear exactly once, on the final collected bit.

The end of a stream can also fall on the sync byte itself, or on a zero code. In those cases the end-of-stream handling meets the header load, or a byte that produces no output. These are checked by comparing the full collected bit sequence and its last markers against a model built from the requirements. A following stream then confirms that the search has restarted.

// File: rtl/rlx_pkg.sv
// Shared types for the run-length bit expander.
// Assumes no more than 255 bits ever come from one code or from the header.
package rlx_pkg;
    localparam int LEN_W = 9;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_CODE = 2'd1,
        ST_EMIT = 2'd2
    } rlx_state_e;
endpackage

// File: rtl/rlx_sync_hunt.sv
// Sync-pair detector: it remembers whether the last byte taken was the lead
// byte, and reports a match when the next byte taken has the marker nibble in
// its upper half. It assumes the caller raises clear whenever it is not searching.
module rlx_sync_hunt #(
    parameter logic [7:0] SYNC_LEAD = 8'hFF,
    parameter logic [3:0] SYNC_NIB  = 4'h3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       clear,
    input  logic [7:0] byte_i,
    output logic       found
);
    logic prev_lead_q;

    // Remember whether the byte just taken was the lead byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            prev_lead_q <= 1'b0;
        else if (take)
            prev_lead_q <= (byte_i == SYNC_LEAD);
    end

    // A match is a taken byte with the marker nibble right after a lead byte.
    always_comb found = take && prev_lead_q && (byte_i[7:4] == SYNC_NIB);
endmodule

// File: rtl/rlx_code_class.sv
// Code classifier: turns one code byte into a run length, the value of the
// body bits, and whether the final bit is the opposite of the body value.
// Purely combinational. It assumes 1 <= MAX_ONES <= 253.
module rlx_code_class
    import rlx_pkg::*;
#(
    parameter int MAX_ONES = 226
) (
    input  logic [7:0]       code,
    output logic [LEN_W-1:0] run_len,
    output logic             run_body,
    output logic             run_tail
);
    localparam logic [7:0] ONES_LIM  = 8'(MAX_ONES);
    localparam logic [7:0] LONG_CODE = 8'(MAX_ONES + 1);
    localparam logic [7:0] SOLO_CODE = 8'hFF;

    // Pick the code class and work out the length and bit values of its run.
    always_comb begin
        run_len  = '0;
        run_body = 1'b0;
        run_tail = 1'b0;
        if (code == 8'd0) begin
            run_len = '0;
        end else if (code <= ONES_LIM) begin
            run_len  = LEN_W'(code) + LEN_W'(1);
            run_body = 1'b1;
            run_tail = 1'b1;
        end else if (code == LONG_CODE) begin
            run_len  = LEN_W'(MAX_ONES);
            run_body = 1'b1;
        end else if (code == SOLO_CODE) begin
            run_len  = LEN_W'(1);
            run_body = 1'b1;
        end else begin
            run_len  = LEN_W'(code) - LEN_W'(MAX_ONES + 1);
            run_body = 1'b0;
            run_tail = 1'b1;
        end
    end
endmodule

// File: rtl/rlx_bit_gen.sv
// Bit generator: counts down the bits still owed. In header mode it shifts out
// a fixed word from its top bit. In run mode it sends the body value and, when
// a tail is set, the opposite value on the final bit. It assumes a load and a
// step never occur in the same cycle.
module rlx_bit_gen
    import rlx_pkg::*;
#(
    parameter int              HDR_LEN  = 16,
    parameter logic [HDR_LEN-1:0] HDR_WORD = 16'hFF20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_hdr,
    input  logic             load_run,
    input  logic [LEN_W-1:0] run_len,
    input  logic             run_body,
    input  logic             run_tail,
    input  logic             step,
    output logic             bit_o,
    output logic             busy,
    output logic             final_o
);
    logic [LEN_W-1:0]   rem_q;
    logic [HDR_LEN-1:0] sh_q;
    logic               hdr_q;
    logic               body_q;
    logic               tail_q;

    // Load the header or a run, or move on by one bit when a bit is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            sh_q   <= '0;
            hdr_q  <= 1'b0;
            body_q <= 1'b0;
            tail_q <= 1'b0;
        end else if (load_hdr) begin
            rem_q <= LEN_W'(HDR_LEN);
            sh_q  <= HDR_WORD;
            hdr_q <= 1'b1;
        end else if (load_run) begin
            rem_q  <= run_len;
            hdr_q  <= 1'b0;
            body_q <= run_body;
            tail_q <= run_tail;
        end else if (step && rem_q != '0) begin
            rem_q <= rem_q - LEN_W'(1);
            sh_q  <= sh_q << 1;
        end
    end

    // Present the current bit, and flag when it is the final one owed.
    always_comb begin
        busy    = (rem_q != '0);
        final_o = (rem_q == LEN_W'(1));
        if (hdr_q)
            bit_o = sh_q[HDR_LEN-1];
        else if (final_o && tail_q)
            bit_o = ~body_q;
        else
            bit_o = body_q;
    end

    // R7: only nonzero runs are ever loaded, so a load never leaves the generator idle
    a_r7_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load_run |=> busy);

    // R3: after a header load the generator has the whole header still to send
    a_r3_hdr_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load_hdr |=> (rem_q == LEN_W'(HDR_LEN)));
endmodule

// File: rtl/rlx_stream_expander.sv
// Top of the run-length bit expander. It sequences the search for the sync
// pair, the header and the code runs. Bytes are taken only while searching or
// while waiting for a code. Bits are offered only while a header or run is
// pending. The end-of-stream flag travels with the byte that carried it.
module rlx_stream_expander
    import rlx_pkg::*;
#(
    parameter int MAX_ONES = 226
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_bit,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_last
);
    rlx_state_e       state_q;
    logic             eos_q;
    logic             accept;
    logic             fire;
    logic             hunt_take;
    logic             hunt_clear;
    logic             hunt_found;
    logic [LEN_W-1:0] cls_len;
    logic             cls_body;
    logic             cls_tail;
    logic             load_run;
    logic             gen_bit;
    logic             gen_busy;
    logic             gen_final;

    // Handshake decode for both sides.
    always_comb begin
        in_ready   = (state_q == ST_HUNT) || (state_q == ST_CODE);
        accept     = in_valid && in_ready;
        out_valid  = (state_q == ST_EMIT);
        out_bit    = gen_bit;
        out_last   = out_valid && eos_q && gen_final;
        fire       = out_valid && out_ready;
        hunt_take  = accept && (state_q == ST_HUNT);
        hunt_clear = (state_q != ST_HUNT) || (accept && in_last);
        load_run   = accept && (state_q == ST_CODE) && (cls_len != '0);
    end

    rlx_sync_hunt u_hunt (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (hunt_take),
        .clear  (hunt_clear),
        .byte_i (in_data),
        .found  (hunt_found)
    );

    rlx_code_class #(.MAX_ONES(MAX_ONES)) u_class (
        .code     (in_data),
        .run_len  (cls_len),
        .run_body (cls_body),
        .run_tail (cls_tail)
    );

    rlx_bit_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_hdr (hunt_found),
        .load_run (load_run),
        .run_len  (cls_len),
        .run_body (cls_body),
        .run_tail (cls_tail),
        .step     (fire),
        .bit_o    (gen_bit),
        .busy     (gen_busy),
        .final_o  (gen_final)
    );

    // Phase sequencing, with the end-of-stream flag following the active byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            eos_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_HUNT: if (hunt_found) begin
                    state_q <= ST_EMIT;
                    eos_q   <= in_last;
                end
                ST_CODE: if (accept) begin
                    if (cls_len != '0) begin
                        state_q <= ST_EMIT;
                        eos_q   <= in_last;
                    end else if (in_last) begin
                        state_q <= ST_HUNT;
                    end
                end
                ST_EMIT: if (fire && gen_final) begin
                    state_q <= eos_q ? ST_HUNT : ST_CODE;
                    eos_q   <= 1'b0;
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R8: no byte is taken while a bit is on offer
    a_r8_no_take_while_emitting: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9: a stalled bit holds its value and markers
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

    // R10: the last marker appears only on an offered bit
    a_r10_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10: once the last bit is taken, output goes quiet and the search resumes
    a_r10_last_ends_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> (!out_valid && in_ready));

    // R8: the generator always has bits owed while output is offered
    a_r8_emit_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> gen_busy);
endmodule

// File: tb/rlx_stream_expander_tb.sv
module rlx_stream_expander_tb;
    localparam int MAX_ONES = 226;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_bit;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       out_last;

    int checks = 0;
    int fails  = 0;

    bit   got_b[$];
    bit   got_l[$];
    bit   exp_b[$];
    logic bp_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_stall = 1'b0;
    logic prev_bit = 1'b0;
    logic prev_last = 1'b0;

    rlx_stream_expander #(.MAX_ONES(MAX_ONES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last)
    );

    always #5 clk = ~clk;

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Drive backpressure, collect taken bits, and watch R8 and R9 at each falling edge.
    always @(negedge clk) begin
        if (bp_mode) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[3];
        end else begin
            out_ready = 1'b1;
        end
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_bit == prev_bit && out_last == prev_last,
                      "R9", "stalled bit changed", {out_valid, out_bit, out_last},
                      {1'b1, prev_bit, prev_last});
            if (out_valid)
                check(!in_ready, "R8", "in_ready while emitting", in_ready, 0);
            if (out_valid && out_ready) begin
                got_b.push_back(out_bit);
                got_l.push_back(out_last);
            end
            prev_stall = out_valid && !out_ready;
            prev_bit   = out_bit;
            prev_last  = out_last;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic last);
        logic ok;
        in_data  = b;
        in_last  = last;
        in_valid = 1'b1;
        forever begin
            ok = in_ready;
            @(negedge clk);
            if (ok) break;
        end
    endtask

    task automatic exp_header();
        for (int i = 15; i >= 0; i--) exp_b.push_back(bit'((16'hFF20 >> i) & 1));
    endtask

    // Expected bits of one code, built from R4 to R7.
    task automatic exp_code(input int b);
        if (b >= 1 && b <= MAX_ONES) begin
            for (int i = 0; i < b; i++) exp_b.push_back(1'b1);
            exp_b.push_back(1'b0);
        end else if (b == MAX_ONES + 1) begin
            for (int i = 0; i < MAX_ONES; i++) exp_b.push_back(1'b1);
        end else if (b >= MAX_ONES + 2 && b <= 254) begin
            for (int i = 0; i < b - (MAX_ONES + 2); i++) exp_b.push_back(1'b0);
            exp_b.push_back(1'b1);
        end else if (b == 255) begin
            exp_b.push_back(1'b1);
        end
    endtask

    // Send a stream, wait for the output to drain, and compare bits and last markers.
    task automatic run_stream(input int bytes[$], input int first_code, input bit expect_last,
                              input string req);
        int mism;
        int first_bad;
        int lastbad;
        got_b.delete();
        got_l.delete();
        exp_b.delete();
        exp_header();
        for (int i = first_code; i < bytes.size(); i++) exp_code(bytes[i]);
        @(negedge clk);
        for (int i = 0; i < bytes.size(); i++)
            send_byte(8'(bytes[i]), i == bytes.size() - 1);
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int t = 0; t < 4000 && got_b.size() < exp_b.size(); t++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(got_b.size() == exp_b.size(), req, "bit count", got_b.size(), exp_b.size());
        mism = 0;
        first_bad = -1;
        lastbad = 0;
        for (int i = 0; i < got_b.size() && i < exp_b.size(); i++) begin
            if (got_b[i] != exp_b[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
            if (got_l[i] != (expect_last && i == exp_b.size() - 1)) lastbad++;
        end
        check(mism == 0, req, "bit mismatches (first index in expected)", mism, 0);
        check(lastbad == 0, "R10", {req, " last-marker placement errors"}, lastbad, 0);
        if (got_b.size() >= 16) begin
            int hdr = 0;
            for (int i = 0; i < 16; i++) hdr = (hdr << 1) | int'(got_b[i]);
            check(hdr == 16'hFF20, "R3", "header word", hdr, 16'hFF20);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0 && out_last == 1'b0, "R1",
              "reset outputs {in_ready,out_valid,out_last}",
              {in_ready, out_valid, out_last}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "after reset {in_ready,out_valid}",
              {in_ready, out_valid}, 2'b10);
    endtask

    // R2: garbage, a lone lead byte, a wrong nibble, then the real pair.
    task automatic test_hunt();
        run_stream('{8'h12, 8'hFF, 8'h20, 8'h30, 8'hFF, 8'hFF, 8'h3A, 255}, 7, 1'b1, "R2");
    endtask

    task automatic test_ones();
        run_stream('{8'hFF, 8'h30, 1, 5, MAX_ONES}, 2, 1'b1, "R4");
    endtask

    task automatic test_long_and_zeros();
        run_stream('{8'hFF, 8'h35, MAX_ONES + 1, MAX_ONES + 2, MAX_ONES + 4, 254, 255, 3},
                   2, 1'b1, "R5 R6");
    endtask

    task automatic test_zero_code();
        run_stream('{8'hFF, 8'h31, 3, 0, 0, 2}, 2, 1'b1, "R7");
    endtask

    // R10: a zero code ends the stream with no marker; the next stream must find its own pair.
    task automatic test_zero_last_then_restart();
        run_stream('{8'hFF, 8'h30, 1, 0}, 2, 1'b0, "R10 zero-end");
        run_stream('{5, 8'hFF, 8'h3F, 2}, 3, 1'b1, "R10 restart");
    endtask

    task automatic test_sync_is_last();
        run_stream('{8'hFF, 8'h30}, 2, 1'b1, "R10 sync-last");
    endtask

    task automatic test_backpressure();
        bp_mode = 1'b1;
        run_stream('{8'hFF, 8'h30, 7, MAX_ONES + 1, MAX_ONES + 9, 0, 255, 2}, 2, 1'b1, "R9");
        run_stream('{8'hFF, 8'h30}, 2, 1'b1, "R9 sync-last");
        bp_mode = 1'b0;
    endtask

    initial begin
        test_reset();
        test_hunt();
        test_ones();
        test_long_and_zeros();
        test_zero_code();
        test_zero_last_then_restart();
        test_sync_is_last();
        test_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule